// File: doc/BRIEF.md
# Asynchronous-Bus Parallel Pixel Writer

This block turns a stream of 20-bit pixels into writes on a 16-bit asynchronous memory-style bus, so that a display can be fed from a general write port. Each pixel's low sixteen bits go out on the data lines. Its top four bits go out on the four lowest address lines, placed under a fixed base address. Every write gives exactly one active-low write-strobe pulse, and the display uses that pulse as its pixel clock.

Each write runs through three timed phases: setup, strobe and hold. Their lengths come from three programmable counts. A count of zero is treated as one. The lengths are captured when a pixel is accepted. Pixels arrive on a valid/ready stream of 32-bit words, and only the low twenty bits are used. When the bus grant is low, the block stays idle with chip select released. This models a stall caused by another bus master. A write that has already started always completes in full. The chip select qualifies the strobe as a pixel clock on a shared bus.

Top module: `pxo_async_out`

## Requirements
- R1: While reset is asserted, and after it, until the first pixel: chip select and write strobe are high (inactive), data is zero, and the address equals the base address with its low four bits zero.
- R2: For an accepted pixel, data_o carries input bits 15:0. addr_o carries input bits 19:16 in bits 3:0 and the base address in the bits above. Input bits 31:20 have no effect on any output.
- R3: Each accepted pixel produces exactly one low pulse on we_no. The pulse starts after the setup count of cycles and lasts the strobe count of cycles.
- R4: cs_no is low for exactly setup+strobe+hold cycles per pixel, and it surrounds the strobe. data_o and addr_o do not change while cs_no is low, except when the next pixel is loaded.
- R5: A programmed length of zero behaves as one. With all lengths at one, a pixel takes 3 cycles.
- R6: pix_ready_o is high when idle with the grant high, and in the final hold cycle with the grant high. Back-to-back pixels therefore run with no idle cycle, and cs_no stays low between them.
- R7: While bus_grant_i is low and the block is idle, cs_no stays high and pix_ready_o is low. A pixel in progress still completes with its full phase lengths.
- R8: After the last write, data_o and addr_o keep their final values.
- R9: Phase lengths are captured when a pixel is accepted. Changing the length inputs during a write does not alter that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| setup_len_i | input | CNT_W | Setup phase length in cycles (0 means 1) |
| strobe_len_i | input | CNT_W | Strobe phase length in cycles (0 means 1) |
| hold_len_i | input | CNT_W | Hold phase length in cycles (0 means 1) |
| bus_grant_i | input | 1 | High when this block may start a write |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | IN_W | Input word; bits 19:0 form the pixel |
| pix_ready_o | output | 1 | Block accepts the pixel this cycle |
| data_o | output | DATA_W | Bus data lines |
| addr_o | output | ADDR_W | Bus address lines |
| cs_no | output | 1 | Active-low chip select |
| we_no | output | 1 | Active-low write strobe (pixel clock) |

## Verification
A pixel is accepted on the clock edge at which valid and ready are both high. The setup phase shows on the bus from the next cycle. The strobe falls setup-count cycles later and lasts strobe-count cycles, and chip select rises setup+strobe+hold cycles after the acceptance edge. The bench drives and samples on the falling edge. It counts cycles from the acceptance edge and checks each output in the cycle the phase arithmetic predicts. The ready output is combinational from the phase state and the grant, so it is checked in the same cycle as the condition that raises it.

// File: rtl/pxo_pkg.sv
package pxo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/pxo_len_timer.sv
module pxo_len_timer
  import pxo_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W-1:0] strobe_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  input  phase_e           phase_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] setup_q, strobe_q, hold_q, cnt_q, len_sel;

  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] l);
    return (l == '0) ? ONE : l;
  endfunction

  // lengths frozen per pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q  <= ONE;
      strobe_q <= ONE;
      hold_q   <= ONE;
    end else if (load_i) begin
      setup_q  <= clamp_len(setup_len_i);
      strobe_q <= clamp_len(strobe_len_i);
      hold_q   <= clamp_len(hold_len_i);
    end
  end

  always_comb begin
    unique case (phase_i)
      PH_SETUP:  len_sel = setup_q;
      PH_STROBE: len_sel = strobe_q;
      PH_HOLD:   len_sel = hold_q;
      default:   len_sel = ONE;
    endcase
  end

  assign last_o = (phase_i != PH_IDLE) && (cnt_q == len_sel - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i || last_o)    cnt_q <= '0;
    else if (phase_i != PH_IDLE)  cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/pxo_phase_fsm.sv
module pxo_phase_fsm
  import pxo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bus_grant_i,
  input  logic   pix_valid_i,
  input  logic   last_i,
  output logic   ready_o,
  output logic   accept_o,
  output phase_e phase_o
);
  phase_e ph_q, ph_d;

  assign ready_o  = bus_grant_i && ((ph_q == PH_IDLE) || ((ph_q == PH_HOLD) && last_i));
  assign accept_o = ready_o && pix_valid_i;
  assign phase_o  = ph_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (accept_o) ph_d = PH_SETUP;
      PH_SETUP:  if (last_i)   ph_d = PH_STROBE;
      PH_STROBE: if (last_i)   ph_d = PH_HOLD;
      PH_HOLD:   if (last_i)   ph_d = accept_o ? PH_SETUP : PH_IDLE;
      default:                 ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  AST_GRANT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE && !bus_grant_i) |=> (ph_q == PH_IDLE));  // R7
  AST_SETUP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SETUP && $past(ph_q) != PH_SETUP) |-> $past(accept_o));  // R6
endmodule

// File: rtl/pxo_out_reg.sv
module pxo_out_reg #(
  parameter int              DATA_W    = 16,
  parameter int              HI_W      = 4,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [DATA_W+HI_W-1:0] pix_i,
  output logic [DATA_W-1:0]      data_o,
  output logic [ADDR_W-1:0]      addr_o
);
  logic [DATA_W-1:0] data_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      hi_q   <= '0;
    end else if (load_i) begin
      data_q <= pix_i[DATA_W-1:0];
      hi_q   <= pix_i[DATA_W+HI_W-1:DATA_W];
    end
  end

  assign data_o = data_q;

  generate
    if (ADDR_W > HI_W) begin : g_base
      assign addr_o = {BASE_ADDR[ADDR_W-1:HI_W], hi_q};
    end else begin : g_nobase
      assign addr_o = hi_q[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pxo_async_out.sv
module pxo_async_out
  import pxo_pkg::*;
#(
  parameter int                IN_W      = 32,
  parameter int                DATA_W    = 16,
  parameter int                HI_W      = 4,
  parameter int                ADDR_W    = 8,
  parameter int                CNT_W     = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  setup_len_i,
  input  logic [CNT_W-1:0]  strobe_len_i,
  input  logic [CNT_W-1:0]  hold_len_i,
  input  logic              bus_grant_i,
  input  logic              pix_valid_i,
  input  logic [IN_W-1:0]   pix_data_i,
  output logic              pix_ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_no,
  output logic              we_no
);
  localparam int PIX_W = DATA_W + HI_W;

  phase_e phase;
  logic   last, accept;
  logic   unused_hi;

  assign unused_hi = ^pix_data_i[IN_W-1:PIX_W];

  pxo_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_grant_i (bus_grant_i),
    .pix_valid_i (pix_valid_i),
    .last_i      (last),
    .ready_o     (pix_ready_o),
    .accept_o    (accept),
    .phase_o     (phase)
  );

  pxo_len_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .setup_len_i  (setup_len_i),
    .strobe_len_i (strobe_len_i),
    .hold_len_i   (hold_len_i),
    .phase_i      (phase),
    .last_o       (last)
  );

  pxo_out_reg #(
    .DATA_W(DATA_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .pix_i  (pix_data_i[PIX_W-1:0]),
    .data_o (data_o),
    .addr_o (addr_o)
  );

  // decoded from registered phase: no combinational hazard on the strobe
  assign cs_no = (phase == PH_IDLE);
  assign we_no = (phase != PH_STROBE);

  AST_WE_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cs_no);  // R4
  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> !$past(cs_no));  // R3
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> !cs_no);  // R4
  AST_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(accept) |-> ($stable(data_o) && $stable(addr_o)));  // R8
  AST_CS_RELEASE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !bus_grant_i) |=> cs_no);  // R7
endmodule

// File: tb/tb_pxo_async_out.sv
module tb_pxo_async_out;
  localparam int          IN_W = 32, DATA_W = 16, HI_W = 4, ADDR_W = 8, CNT_W = 4;
  localparam logic [7:0]  BASE = 8'hA0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] s_len = 4'd1, t_len = 4'd1, h_len = 4'd1;
  logic grant = 1'b1, valid = 1'b0;
  logic [IN_W-1:0] pix = '0;
  logic ready, cs_n, we_n;
  logic [DATA_W-1:0] data;
  logic [ADDR_W-1:0] addr;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pxo_async_out #(
    .IN_W(IN_W), .DATA_W(DATA_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_ADDR(BASE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .setup_len_i(s_len), .strobe_len_i(t_len), .hold_len_i(h_len),
    .bus_grant_i(grant), .pix_valid_i(valid), .pix_data_i(pix),
    .pix_ready_o(ready), .data_o(data), .addr_o(addr), .cs_no(cs_n), .we_no(we_n)
  );

  // {setup, strobe, hold, pixel}
  localparam int NV = 6;
  localparam logic [43:0] VEC [NV] = '{
    {4'd1, 4'd1, 4'd1, 32'h000A_5A5A},
    {4'd1, 4'd2, 4'd3, 32'hFFF5_1234},
    {4'd0, 4'd0, 4'd0, 32'h000F_0001},
    {4'd4, 4'd1, 4'd2, 32'h0008_0000},
    {4'd3, 4'd5, 4'd4, 32'h1237_6543},
    {4'd2, 4'd0, 4'd1, 32'hABC0_FFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  // accept one pixel, then watch the write; lengths scrambled after acceptance (R9)
  task automatic run_pixel(input logic [3:0] s, input logic [3:0] t, input logic [3:0] h,
                           input logic [31:0] px, input bit drop_grant);
    int cs_cnt = 0, we_cnt = 0, we_first = -1, falls = 0;
    bit prev_we = 1'b1, bad_bus = 1'b0;
    logic [15:0] ed = px[15:0];
    logic [7:0]  ea = {BASE[7:4], px[19:16]};
    @(negedge clk);
    s_len = s; t_len = t; h_len = h; pix = px; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0; s_len = 4'hF; t_len = 4'hF; h_len = 4'hF;
    if (drop_grant) grant = 1'b0;
    for (int c = 0; c < 64; c++) begin
      if (cs_n) break;
      cs_cnt++;
      if (!we_n) begin
        if (we_first < 0) we_first = c;
        we_cnt++;
        if (prev_we) falls++;
      end
      if (data !== ed || addr !== ea) bad_bus = 1'b1;
      prev_we = we_n;
      @(negedge clk);
    end
    chk(we_first == eff(s), "R3 strobe start", we_first, eff(s));
    chk(we_cnt == eff(t), "R3 strobe length", we_cnt, eff(t));
    chk(falls == 1, "R3 one pulse", falls, 1);
    chk(cs_cnt == eff(s) + eff(t) + eff(h), "R4/R5 cs length", cs_cnt, eff(s) + eff(t) + eff(h));
    chk(!bad_bus, "R4 bus stable", {data, 8'h0, addr}, {ed, 8'h0, ea});
    chk(data === ed, "R2 data", data, ed);
    chk(addr === ea, "R2 addr", addr, ea);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1 && we_n === 1'b1, "R1 strobes idle in reset", {cs_n, we_n}, 2'b11);
    chk(data === '0, "R1 data in reset", data, 0);
    chk(addr === BASE, "R1 addr in reset", addr, BASE);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && ready === 1'b1, "R1 idle after reset", {cs_n, ready}, 2'b11);

    for (int i = 0; i < NV; i++)
      run_pixel(VEC[i][43:40], VEC[i][39:36], VEC[i][35:32], VEC[i][31:0], 1'b0);

    // R8 last values persist
    repeat (5) @(negedge clk);
    chk(data === 16'hFFFF && addr === 8'hA0, "R8 hold final", {data, addr}, {16'hFFFF, 8'hA0});

    // R6 back-to-back, 1/1/1
    begin
      logic [5:0] we_seq, cs_seq;
      bit rdy_hold;
      @(negedge clk);
      s_len = 1; t_len = 1; h_len = 1; valid = 1'b1; pix = 32'h0001_1111;
      @(negedge clk);                 // c0: SETUP of A
      pix = 32'h0002_2222;
      for (int c = 0; c < 6; c++) begin
        we_seq[c] = we_n; cs_seq[c] = cs_n;
        if (c == 2) rdy_hold = ready;
        if (c == 4) chk(data === 16'h2222 && addr === 8'hA2, "R6 second pixel bus", {data, addr}, {16'h2222, 8'hA2});
        if (c == 3) valid = 1'b0;
        @(negedge clk);
      end
      chk(rdy_hold, "R6 ready in last hold", rdy_hold, 1);
      chk(cs_seq == 6'b0, "R6 no gap in cs", cs_seq, 0);
      chk(we_seq == 6'b101101, "R6 strobe cadence 3 cycles", we_seq, 6'b101101);
      chk(cs_n === 1'b1, "R6 idle after pair", cs_n, 1);
    end

    // R7 grant low while idle
    begin
      bit bad = 1'b0;
      grant = 1'b0; valid = 1'b1; pix = 32'h0004_4444;
      repeat (5) begin
        @(negedge clk);
        if (cs_n !== 1'b1 || ready !== 1'b0) bad = 1'b1;
      end
      chk(!bad, "R7 stalled while grant low", {cs_n, ready}, 2'b10);
      chk(data === 16'h2222, "R7 no load while stalled", data, 16'h2222);
      valid = 1'b0; grant = 1'b1;
    end

    // R7 grant drop mid-pixel: write completes fully
    run_pixel(4'd2, 4'd2, 4'd2, 32'h0006_6666, 1'b1);
    begin
      bit bad = 1'b0;
      valid = 1'b1; pix = 32'h0007_7777;
      repeat (4) begin
        @(negedge clk);
        if (cs_n !== 1'b1 || ready !== 1'b0) bad = 1'b1;
      end
      chk(!bad, "R7 idle after drop", {cs_n, ready}, 2'b10);
      valid = 1'b0; grant = 1'b1;
    end

    // R2 upper bits ignored: same low 20 bits, different 31:20
    run_pixel(4'd1, 4'd1, 4'd1, 32'hFFF3_ABCD, 1'b0);
    run_pixel(4'd1, 4'd1, 4'd1, 32'h0003_ABCD, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule